// File: doc/BRIEF.md
# Segment-Indexed DAC Correction Store

This block sits beside the code register of a precision digital-to-analog converter and supplies the digital correction values that steer its trim circuitry. The top five bits of each code select one of 32 segments. Segment zero always maps to a correction of zero. Each of the other 31 segments has its own stored 12-bit linearity-correction word. The block also holds a 6-bit gain-trim code and a single polarity bit. When that bit is set, the converter runs in bipolar mode with a doubled feedback resistance. When it is clear, the converter runs in unipolar mode with the single feedback resistance.

Unipolar and bipolar operation need different correction tables, so the store keeps two banks of 31 words. The polarity bit chooses which bank feeds the lookup. One write strobe and one data bus are shared by two modes:
- **Normal mode:** `prog_n` is high. A strobe loads the code register, and in the same clock edge the correction register is loaded from the store.
- **Programming mode:** `prog_n` is low. The same strobe and data bus write the store, or write the trim word, at the address given on `prog_addr`.

Top module: `segcorr_store`

## Requirements
- R1: While `rst` is high at a clock edge, `dac_code`, `corr_code`, `gain_code` and `bipolar` become zero.
- R2: A strobe with `prog_n` high loads `code_in` into `dac_code`, visible one clock after the strobe edge.
- R3: In that same edge, `corr_code` takes the stored word of segment `code_in[13:9]`, for segments 1 to 31.
- R4: A load whose segment `code_in[13:9]` is 0 gives `corr_code` = 0.
- R5: The lookup reads bank 0 when `bipolar` is 0 and bank 1 when `bipolar` is 1, using the value `bipolar` holds at the load edge.
- R6: A strobe with `prog_n` low and `prog_addr[4:0]` in 1..31 stores `code_in[11:0]` as the word of entry `prog_addr[4:0]` in bank `prog_addr[5]`. It leaves `dac_code` and `corr_code` unchanged.
- R7: A strobe with `prog_n` low and `prog_addr[4:0]` = 0 (either bank) sets `gain_code` to `code_in[5:0]` and `bipolar` to `code_in[13]`, one clock later.
- R8: A strobe with `prog_n` high changes neither the store nor `gain_code` nor `bipolar`, whatever `prog_addr` holds.
- R9: With `wr_stb` low, all outputs hold their values.
- R10: Changing `bipolar` does not alter `corr_code` until the next code load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe shared by loading and programming |
| prog_n | input | 1 | Programming enable, active low; held high in normal use |
| prog_addr | input | 6 | Bit 5 selects the bank; bits 4:0 select the entry (0 = trim word) |
| code_in | input | 14 | Shared data bus: the DAC code, or programming data |
| dac_code | output | 14 | Registered DAC code |
| corr_code | output | 12 | Registered linearity-correction code for `dac_code` |
| gain_code | output | 6 | Held gain-trim code |
| bipolar | output | 1 | Polarity setting: 1 = bipolar with doubled feedback, 0 = unipolar |

## Verification
A wrong stored word, or a wrong bank or segment decode, stays hidden until a code in the affected segment is loaded. It then shows as a bad `corr_code` on the very next clock. For this reason every segment of both banks is loaded with several low-bit patterns.

A programming write that leaks into the code or correction register shows one clock after the strobe. A leak the other way, from a normal load into the store or the trim register, shows either directly on `gain_code` and `bipolar`, or on `corr_code` the next time the damaged entry is read back.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_TRIM  = 2'd2,
    OP_ENTRY = 2'd3
  } scs_op_e;
endpackage

// File: rtl/scs_ctrl.sv
module scs_ctrl
  import scs_pkg::*;
#(
  parameter int SEL_W = 5
) (
  input  logic           wr_stb,
  input  logic           prog_n,
  input  logic [SEL_W:0] prog_addr,
  output scs_op_e        op
);
  // Decode one strobe into load, trim write or entry write
  always_comb begin
    if (!wr_stb)                          op = OP_IDLE;
    else if (prog_n)                      op = OP_LOAD;
    else if (prog_addr[SEL_W-1:0] == '0)  op = OP_TRIM;
    else                                  op = OP_ENTRY;
  end
endmodule

// File: rtl/scs_corr_ram.sv
module scs_corr_ram #(
  parameter int SEL_W  = 5,
  parameter int CORR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W:0]    waddr,
  input  logic [CORR_W-1:0] wdata,
  input  logic              re,
  input  logic [SEL_W:0]    raddr,
  output logic [CORR_W-1:0] corr_q
);
  localparam int DEPTH = 1 << (SEL_W + 1);

  logic [CORR_W-1:0] mem [DEPTH];

  // Write port: no reset, so the array maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read; segment zero is forced to a zero correction
  always_ff @(posedge clk) begin
    if (rst)                            corr_q <= '0;
    else if (re) begin
      if (raddr[SEL_W-1:0] == '0)       corr_q <= '0;
      else                              corr_q <= mem[raddr];
    end
  end
endmodule

// File: rtl/scs_trim_reg.sv
module scs_trim_reg #(
  parameter int GAIN_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [GAIN_W-1:0] gain_d,
  input  logic              mode_d,
  output logic [GAIN_W-1:0] gain_q,
  output logic              mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      gain_q <= '0;
      mode_q <= 1'b0;
    end else if (we) begin
      gain_q <= gain_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/scs_code_reg.sv
module scs_code_reg #(
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              le,
  input  logic [CODE_W-1:0] d,
  output logic [CODE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (le) q <= d;
  end
endmodule

// File: rtl/segcorr_store.sv
module segcorr_store
  import scs_pkg::*;
#(
  parameter int CODE_W = 14,
  parameter int SEL_W  = 5,
  parameter int CORR_W = 12,
  parameter int GAIN_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              prog_n,
  input  logic [SEL_W:0]    prog_addr,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] dac_code,
  output logic [CORR_W-1:0] corr_code,
  output logic [GAIN_W-1:0] gain_code,
  output logic              bipolar
);
  localparam int SEG_LO = CODE_W - SEL_W;

  scs_op_e          op;
  logic [SEL_W-1:0] seg;
  logic [SEL_W:0]   rd_addr;

  assign seg     = code_in[CODE_W-1:SEG_LO];
  assign rd_addr = {bipolar, seg};

  scs_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .wr_stb    (wr_stb),
    .prog_n    (prog_n),
    .prog_addr (prog_addr),
    .op        (op)
  );

  scs_code_reg #(.CODE_W(CODE_W)) u_code (
    .clk (clk),
    .rst (rst),
    .le  (op == OP_LOAD),
    .d   (code_in),
    .q   (dac_code)
  );

  scs_corr_ram #(.SEL_W(SEL_W), .CORR_W(CORR_W)) u_ram (
    .clk    (clk),
    .rst    (rst),
    .we     (op == OP_ENTRY),
    .waddr  (prog_addr),
    .wdata  (code_in[CORR_W-1:0]),
    .re     (op == OP_LOAD),
    .raddr  (rd_addr),
    .corr_q (corr_code)
  );

  scs_trim_reg #(.GAIN_W(GAIN_W)) u_trim (
    .clk    (clk),
    .rst    (rst),
    .we     (op == OP_TRIM),
    .gain_d (code_in[GAIN_W-1:0]),
    .mode_d (code_in[CODE_W-1]),
    .gain_q (gain_code),
    .mode_q (bipolar)
  );
endmodule

// File: rtl/scs_checker.sv
module scs_checker #(
  parameter int CODE_W = 14,
  parameter int SEL_W  = 5,
  parameter int CORR_W = 12,
  parameter int GAIN_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic              prog_n,
  input logic [SEL_W:0]    prog_addr,
  input logic [CODE_W-1:0] code_in,
  input logic [CODE_W-1:0] dac_code,
  input logic [CORR_W-1:0] corr_code,
  input logic [GAIN_W-1:0] gain_code,
  input logic              bipolar
);
  // R2
  code_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && prog_n) |=> (dac_code == $past(code_in)));

  // R4
  seg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && prog_n && code_in[CODE_W-1 -: SEL_W] == '0) |=> (corr_code == '0));

  // R6
  prog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !prog_n) |=> ($stable(dac_code) && $stable(corr_code)));

  // R7
  trim_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !prog_n && prog_addr[SEL_W-1:0] == '0) |=>
      (gain_code == $past(code_in[GAIN_W-1:0]) && bipolar == $past(code_in[CODE_W-1])));

  // R8
  trim_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && prog_n) |=> ($stable(gain_code) && $stable(bipolar)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> ($stable(dac_code) && $stable(corr_code) && $stable(gain_code) && $stable(bipolar)));
endmodule

bind segcorr_store scs_checker #(
  .CODE_W(CODE_W), .SEL_W(SEL_W), .CORR_W(CORR_W), .GAIN_W(GAIN_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_stb    (wr_stb),
  .prog_n    (prog_n),
  .prog_addr (prog_addr),
  .code_in   (code_in),
  .dac_code  (dac_code),
  .corr_code (corr_code),
  .gain_code (gain_code),
  .bipolar   (bipolar)
);

// File: tb/segcorr_store_bench.sv
module segcorr_store_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_stb = 1'b0;
  logic        prog_n = 1'b1;
  logic [5:0]  prog_addr = '0;
  logic [13:0] code_in = '0;
  logic [13:0] dac_code;
  logic [11:0] corr_code;
  logic [5:0]  gain_code;
  logic        bipolar;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segcorr_store u_segcorr_store (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .prog_n(prog_n),
    .prog_addr(prog_addr), .code_in(code_in), .dac_code(dac_code),
    .corr_code(corr_code), .gain_code(gain_code), .bipolar(bipolar)
  );

  // Pattern stored in bank b, entry e; segment 0 always yields zero
  function automatic int entry_val(int b, int e);
    if (e == 0) return 0;
    return (e * 149 + b * 1331 + 7) % 4096;
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one strobe at a falling edge; returns at the next falling edge
  task automatic op(input logic w, input logic pn, input logic [5:0] a, input logic [13:0] d);
    @(negedge clk);
    wr_stb = w; prog_n = pn; prog_addr = a; code_in = d;
    @(negedge clk);
    wr_stb = 1'b0; prog_n = 1'b1;
  endtask

  task automatic sweep(int bank);
    for (int s = 0; s < 32; s++) begin
      for (int k = 0; k < 4; k++) begin
        logic [13:0] c;
        c = 14'((s << 9) | ((k * 131 + s * 7) & 9'h1FF));
        op(1'b1, 1'b1, 6'd0, c);
        chk("R2", int'(dac_code), int'(c));
        if (s == 0) chk("R4", int'(corr_code), 0);
        else        chk(bank ? "R5" : "R3", int'(corr_code), entry_val(bank, s));
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(dac_code), 0);
    chk("R1", int'(corr_code), 0);
    chk("R1", int'(gain_code), 0);
    chk("R1", int'(bipolar), 0);
    @(negedge clk); rst = 1'b0;

    // Program both banks; code and correction registers must not move (R6)
    for (int b = 0; b < 2; b++) begin
      for (int e = 1; e < 32; e++) begin
        op(1'b1, 1'b0, 6'((b << 5) | e), 14'(entry_val(b, e)));
        chk("R6", int'(dac_code), 0);
        chk("R6", int'(corr_code), 0);
      end
    end

    // Trim word: gain 0x2A, unipolar (R7)
    op(1'b1, 1'b0, 6'd0, 14'h002A);
    chk("R7", int'(gain_code), 'h2A);
    chk("R7", int'(bipolar), 0);

    sweep(0);

    // Idle: everything holds (R9)
    repeat (3) @(negedge clk);
    chk("R9", int'(dac_code), int'(14'(31 << 9) | ((3 * 131 + 31 * 7) & 9'h1FF)));
    chk("R9", int'(corr_code), entry_val(0, 31));
    chk("R9", int'(gain_code), 'h2A);

    // Load with trim-like address and bit 13 set: trim untouched (R8)
    op(1'b1, 1'b1, 6'd0, 14'h2011);
    chk("R8", int'(gain_code), 'h2A);
    chk("R8", int'(bipolar), 0);
    chk("R2", int'(dac_code), 'h2011);
    chk("R3", int'(corr_code), entry_val(0, 16));

    // Switch to bipolar through the bank-1 trim address (R7, R10)
    op(1'b1, 1'b0, 6'd32, 14'h2015);
    chk("R7", int'(gain_code), 'h15);
    chk("R7", int'(bipolar), 1);
    chk("R10", int'(corr_code), entry_val(0, 16));
    op(1'b1, 1'b1, 6'd0, 14'h2011);
    chk("R5", int'(corr_code), entry_val(1, 16));

    sweep(1);

    // Rewrite one bipolar entry, then read it back (R6)
    op(1'b1, 1'b0, 6'd37, 14'h3ABC);
    chk("R6", int'(corr_code), entry_val(1, 31) );
    op(1'b1, 1'b1, 6'd0, 14'(5 << 9));
    chk("R6", int'(corr_code), 'hABC);

    // Back to unipolar: bank 0 entry 5 must be intact (R5, R8)
    op(1'b1, 1'b0, 6'd0, 14'h0002);
    op(1'b1, 1'b1, 6'd0, 14'(5 << 9) | 14'h1);
    chk("R5", int'(corr_code), entry_val(0, 5));
    chk("R8", int'(gain_code), 'h02);

    // Reset again clears outputs (R1)
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1", int'(dac_code), 0);
    chk("R1", int'(corr_code), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule